// File: doc/BRIEF.md
# ADC Threshold Comparator Interrupt Unit

This block sits behind an auxiliary ADC. It watches the stream of conversion results, each a channel number, a 12-bit code and a valid strobe. Four digital comparators run on that stream independently. Each comparator has its own source channel, threshold and direction. The block holds sticky interrupt flags: one says that a new result has arrived, and one per comparator says that its threshold has been crossed.

Software configures the comparators and manages the flags through a small register port. Writes take effect at the clock edge and reads are combinational. Flags are cleared by writing 1 to them. A mask bit suppresses a flag's contribution to the single interrupt line `irq`, and every mask bit starts out masked. Masking never stops a flag from latching.

Register map, by address:
- 0 is the status register. Comparator n's flag is in bit 3+n, so comparators 1 to 4 use bits 4 to 7. The data-ready flag is bit 8.
- 1 is the mask register, with the same layout as status.
- 2 to 5 hold the configuration of comparators 1 to 4. Bits 11:0 are the threshold, bits 14:12 the source channel and bit 15 the direction.
- 6 holds the last result, with the code in bits 11:0 and the channel in bits 14:12.

Top module: `adc_thresh_irq`

## Requirements
- R1: After reset, status reads 0 and every configuration register reads 0. The mask register reads 0x1F0, meaning every flag is masked, and `irq` is low.
- R2: The data-ready flag (status bit 8) sets on a rising edge of `resValid`. If `resValid` is held high over several cycles, it sets the flag only once.
- R3: With direction bit 15 = 0, a comparator trips when the code is below its threshold. With bit 15 = 1, it trips when the code is greater than or equal to its threshold.
- R4: A comparator evaluates only those samples whose channel equals its source field (bits 14:12).
- R5: A comparator flag sets only when the compare condition goes from false to true on a matching sample. A run of samples that all meet the condition sets the flag only once.
- R6: Writing 1 to a status bit clears that bit, and writing 0 leaves it unchanged. Reading any register never clears a flag, and address 6 returns the last result.
- R7: If a set event and a write-1 clear of the same flag fall in the same cycle, the flag ends up set.
- R8: Flags latch whether or not they are masked. `irq` is high exactly when some flag is set and its mask bit in register 1 is 0.
- R9: When a comparator's source field is changed, its false/true history resets. The next matching sample that meets the condition then trips it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | Conversion result valid |
| resChan | input | 3 | Channel of the result |
| resCode | input | 12 | Unsigned conversion code |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (read and write) |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Combinational read data at `regAddr` |
| irq | output | 1 | Aggregate interrupt |

## Verification
The hardest situation to reach is a clear that falls on the same edge as a set, because both the register port and the result bus must act together. The bench drives a write of 1 to the data-ready bit on the same clock edge as a fresh rising `resValid`. The condition-edge rule and the history reset on a source change are also hard to reach. The bench reaches them with sample sequences that keep a comparator's condition true across a clear, and then moves the comparator to another channel while its history still reads true.

// File: rtl/adc_thresh_pkg.sv
package adc_thresh_pkg;
  localparam int CODE_W   = 12;
  localparam int CHAN_W   = 3;
  localparam int NUM_CMP  = 4;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int NFLAG    = NUM_CMP + 1;   // comparators first, data-ready on top
  localparam int STAT_LSB = 4;
  localparam int SRC_LSB  = 12;
  localparam int DIR_BIT  = 15;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RESULT = 3'd6;

  typedef struct packed {
    logic [NFLAG-1:0]   clrFlags;
    logic               maskWr;
    logic [NUM_CMP-1:0] cfgWr;
    logic [DATA_W-1:0]  data;
  } strobe_t;
endpackage

// File: rtl/adc_thresh_ctrl.sv
module adc_thresh_ctrl
  import adc_thresh_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strb
);
  always_comb begin
    strb      = '0;
    strb.data = wrData;
    if (wrEn) begin
      if (regAddr == A_STATUS) strb.clrFlags = wrData[STAT_LSB +: NFLAG];
      if (regAddr == A_MASK)   strb.maskWr   = 1'b1;
      for (int i = 0; i < NUM_CMP; i++)
        if (regAddr == ADDR_W'(int'(A_CFG0) + i)) strb.cfgWr[i] = 1'b1;
    end
  end
endmodule

// File: rtl/adc_thresh_cmp.sv
module adc_thresh_cmp
  import adc_thresh_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              resValid,
  input  logic [CHAN_W-1:0] resChan,
  input  logic [CODE_W-1:0] resCode,
  output logic              hit,
  output logic [DATA_W-1:0] cfgOut
);
  logic [CODE_W-1:0] thr;
  logic [CHAN_W-1:0] src;
  logic              gtEq;
  logic              prevCond;
  logic              match;
  logic              cond;

  assign match = resValid && (resChan == src);
  assign cond  = gtEq ? (resCode >= thr) : (resCode < thr);
  assign hit   = match && cond && !prevCond;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thr      <= '0;
      src      <= '0;
      gtEq     <= 1'b0;
      prevCond <= 1'b0;
    end else if (cfgWr) begin
      thr  <= cfgData[CODE_W-1:0];
      src  <= cfgData[SRC_LSB +: CHAN_W];
      gtEq <= cfgData[DIR_BIT];
      if (cfgData[SRC_LSB +: CHAN_W] != src) prevCond <= 1'b0;
    end else if (match) begin
      prevCond <= cond;
    end
  end

  always_comb begin
    cfgOut                     = '0;
    cfgOut[CODE_W-1:0]         = thr;
    cfgOut[SRC_LSB +: CHAN_W]  = src;
    cfgOut[DIR_BIT]            = gtEq;
  end
endmodule

// File: rtl/adc_thresh_dp.sv
module adc_thresh_dp
  import adc_thresh_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              resValid,
  input  logic [CHAN_W-1:0] resChan,
  input  logic [CODE_W-1:0] resCode,
  output logic [DATA_W-1:0] rdData,
  output logic [NFLAG-1:0]  flags,
  output logic [NFLAG-1:0]  maskBits,
  output logic              irq
);
  logic [NUM_CMP-1:0]       hits;
  logic [DATA_W-1:0]        cfgRd [NUM_CMP];
  logic                     prevValid;
  logic [CHAN_W-1:0]        lastChan;
  logic [CODE_W-1:0]        lastCode;
  logic [NFLAG-1:0]         setEv;

  for (genvar g = 0; g < NUM_CMP; g++) begin : gCmp
    adc_thresh_cmp uCmp (
      .clk      (clk),
      .rstN     (rstN),
      .cfgWr    (strb.cfgWr[g]),
      .cfgData  (strb.data),
      .resValid (resValid),
      .resChan  (resChan),
      .resCode  (resCode),
      .hit      (hits[g]),
      .cfgOut   (cfgRd[g])
    );
  end

  assign setEv = {resValid && !prevValid, hits};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags     <= '0;
      maskBits  <= '1;
      prevValid <= 1'b0;
      lastChan  <= '0;
      lastCode  <= '0;
    end else begin
      flags     <= (flags & ~strb.clrFlags) | setEv;
      prevValid <= resValid;
      if (strb.maskWr) maskBits <= strb.data[STAT_LSB +: NFLAG];
      if (resValid) begin
        lastChan <= resChan;
        lastCode <= resCode;
      end
    end
  end

  assign irq = |(flags & ~maskBits);

  always_comb begin
    rdData = '0;
    if (regAddr == A_STATUS) rdData[STAT_LSB +: NFLAG] = flags;
    if (regAddr == A_MASK)   rdData[STAT_LSB +: NFLAG] = maskBits;
    if (regAddr == A_RESULT) begin
      rdData[CODE_W-1:0]        = lastCode;
      rdData[SRC_LSB +: CHAN_W] = lastChan;
    end
    for (int i = 0; i < NUM_CMP; i++)
      if (regAddr == ADDR_W'(int'(A_CFG0) + i)) rdData = cfgRd[i];
  end
endmodule

// File: rtl/adc_thresh_irq.sv
module adc_thresh_irq
  import adc_thresh_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [CHAN_W-1:0] resChan,
  input  logic [CODE_W-1:0] resCode,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  strobe_t          strb;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] maskBits;

  adc_thresh_ctrl uCtrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .strb    (strb)
  );

  adc_thresh_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regAddr  (regAddr),
    .resValid (resValid),
    .resChan  (resChan),
    .resCode  (resCode),
    .rdData   (rdData),
    .flags    (flags),
    .maskBits (maskBits),
    .irq      (irq)
  );
endmodule

// File: rtl/adc_thresh_chk.sv
module adc_thresh_chk
  import adc_thresh_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              resValid,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  maskBits,
  input logic              irq
);
  logic statWr;
  logic rdyClr;
  assign statWr = wrEn && (regAddr == A_STATUS);
  assign rdyClr = statWr && wrData[STAT_LSB + NUM_CMP];

  AST_RDY_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !$past(resValid)) |=> flags[NUM_CMP]); // R7

  AST_RDY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flags[NUM_CMP] && !rdyClr) |=> flags[NUM_CMP]); // R6

  AST_RDY_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (rdyClr && !(resValid && !$past(resValid))) |=> !flags[NUM_CMP]); // R6

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && wrData[STAT_LSB +: NFLAG] == '0) |=> (($past(flags) & ~flags) == '0)); // R6

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&maskBits) |-> !irq); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags != '0)); // R8
endmodule

bind adc_thresh_irq adc_thresh_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .regAddr  (regAddr),
  .wrData   (wrData),
  .resValid (resValid),
  .flags    (flags),
  .maskBits (maskBits),
  .irq      (irq)
);

// File: tb/adc_thresh_irq_bench.sv
module adc_thresh_irq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic [2:0]  resChan = '0;
  logic [11:0] resCode = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;
  int          nRun = 0;
  int          nFail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  adc_thresh_irq u_adc_thresh_irq (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan),
    .resCode(resCode), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sample(input logic [2:0] ch, input logic [11:0] code);
    @(negedge clk);
    resValid = 1'b1; resChan = ch; resCode = code;
    @(negedge clk);
    resValid = 1'b0;
  endtask

  task automatic clearAll();
    writeReg(3'd0, 16'h01F0);
  endtask

  task automatic tReset();
    logic [15:0] v;
    readReg(3'd0, v); check("R1 status", v, 16'h0000);
    readReg(3'd1, v); check("R1 mask", v, 16'h01F0);
    readReg(3'd3, v); check("R1 cfg", v, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);
  endtask

  task automatic tReady();
    logic [15:0] v;
    sample(3'd5, 12'hABC);
    readReg(3'd0, v); check("R2 ready set", v & 16'h0100, 16'h0100);
    readReg(3'd6, v); check("R6 last result", v, 16'h5ABC);
    readReg(3'd0, v); check("R6 read keeps flag", v & 16'h0100, 16'h0100);
    writeReg(3'd0, 16'h0000);
    readReg(3'd0, v); check("R6 zero write no effect", v & 16'h0100, 16'h0100);
    writeReg(3'd0, 16'h0100);
    readReg(3'd0, v); check("R6 w1c", v & 16'h0100, 16'h0000);
    // held valid: one rise only
    @(negedge clk);
    resValid = 1'b1; resChan = 3'd0; resCode = 12'h001;
    @(negedge clk);
    readReg(3'd0, v); check("R2 rise sets", v & 16'h0100, 16'h0100);
    wrEn = 1'b1; regAddr = 3'd0; wrData = 16'h0100;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    resValid = 1'b0;
    readReg(3'd0, v); check("R2 held valid no reset", v & 16'h0100, 16'h0000);
  endtask

  task automatic tDirection();
    logic [15:0] v;
    writeReg(3'd2, 16'hD800);  // cmp1: >= 0x800 on ch5
    writeReg(3'd3, 16'h5100);  // cmp2: < 0x100 on ch5
    readReg(3'd2, v); check("R3 cfg readback", v, 16'hD800);
    clearAll();
    sample(3'd5, 12'h7FF);
    readReg(3'd0, v); check("R3 below ge-threshold", v & 16'h00F0, 16'h0000);
    sample(3'd5, 12'h800);
    readReg(3'd0, v); check("R3 equal trips ge", v & 16'h00F0, 16'h0010);
    clearAll();
    sample(3'd5, 12'h100);
    readReg(3'd0, v); check("R3 equal not lt", v & 16'h0020, 16'h0000);
    sample(3'd5, 12'h0FF);
    readReg(3'd0, v); check("R3 lt trips", v & 16'h0020, 16'h0020);
  endtask

  task automatic tChannelAndEdge();
    logic [15:0] v;
    writeReg(3'd4, 16'hF010);  // cmp3: >= 0x010 on ch7
    clearAll();
    sample(3'd5, 12'hFFF);
    readReg(3'd0, v); check("R4 other channel ignored", v & 16'h0040, 16'h0000);
    sample(3'd7, 12'h020);
    readReg(3'd0, v); check("R4 own channel trips", v & 16'h0040, 16'h0040);
    clearAll();
    sample(3'd7, 12'h030);
    readReg(3'd0, v); check("R5 still true no retrip", v & 16'h0040, 16'h0000);
    sample(3'd7, 12'h000);
    sample(3'd7, 12'h020);
    readReg(3'd0, v); check("R5 false to true trips", v & 16'h0040, 16'h0040);
    clearAll();
    writeReg(3'd4, 16'hE010);  // move cmp3 to ch6
    sample(3'd6, 12'h020);
    readReg(3'd0, v); check("R9 source change resets history", v & 16'h0040, 16'h0040);
  endtask

  task automatic tSetWins();
    logic [15:0] v;
    clearAll();
    @(negedge clk);
    resValid = 1'b1; resChan = 3'd0; resCode = 12'h000;
    wrEn = 1'b1; regAddr = 3'd0; wrData = 16'h0100;
    @(negedge clk);
    resValid = 1'b0; wrEn = 1'b0;
    readReg(3'd0, v); check("R7 set beats clear", v & 16'h0100, 16'h0100);
  endtask

  task automatic tMask();
    logic [15:0] v;
    clearAll();
    check("R8 no flags irq low", {15'b0, irq}, 16'h0000);
    sample(3'd0, 12'h000);
    readReg(3'd0, v); check("R8 latch while masked", v & 16'h0100, 16'h0100);
    check("R8 masked irq low", {15'b0, irq}, 16'h0000);
    writeReg(3'd1, 16'h00F0);
    check("R8 unmasked irq high", {15'b0, irq}, 16'h0001);
    writeReg(3'd1, 16'h01E0);
    readReg(3'd1, v); check("R8 mask readback", v, 16'h01E0);
    check("R8 other bit unmasked irq low", {15'b0, irq}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tReady();
    tDirection();
    tChannelAndEdge();
    tSetWins();
    tMask();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule